// File: doc/BRIEF.md
# Four-Channel Cycle-Steal Byte Mover

This block moves single bytes between locations on a simple memory bus on behalf of four peripherals. Each channel holds a source pointer, a destination pointer, a remaining-unit counter and a control word. A peripheral raises its request line when it has a byte ready or wants one. The block picks one requesting channel, reads one byte from that channel's source and writes it to the destination. It then moves each pointer on as that channel's control word selects, decrements the counter and releases the bus. Another request is chosen only after that.

Software programs the channels and a global word through a small register port. The global word holds a master run bit and a latched non-maskable-interrupt flag. When that flag is set, no new transfer starts. Each channel reports completion through a sticky end bit and an interrupt output.

Top module: `dma4_ctrl`

## Requirements
- R1: After a synchronous reset every channel register, the global word, `cfg_rdata`, `dack`, `irq`, `mem_rd` and `mem_wr` are zero.
- R2: A transfer takes three cycles. In the first cycle `mem_rd` is high with `mem_addr` equal to the source pointer, and `dack` pulses for exactly one cycle on the served channel. In the second cycle `mem_wr` is high with `mem_addr` equal to the destination pointer and `mem_wdata` equal to the byte read. `mem_rd` and `mem_wr` are never high together.
- R3: Control bit 1 makes the source pointer step by one after each unit and control bit 2 does the same for the destination pointer. A pointer whose bit is clear stays fixed.
- R4: The counter (field offset 2) drops by one per unit. When it reaches zero, end bit 4 of the control word is set and the channel stops serving requests. A channel whose counter is zero never starts.
- R5: `irq[n]` is high one cycle after channel n has both end bit 4 and enable bit 3 set.
- R6: When several channels are eligible in the same cycle, the service order is channel 0, then 3, then 2, then 1.
- R7: A channel is served only when its enable bit 0 and the master bit 0 of the global word (address 16) are both set.
- R8: A one-cycle pulse on `nmi` sets global bit 1 whether or not a transfer is running. While that bit is set no transfer starts. Writing 0 to the bit clears it, and writing 1 to it has no effect.
- R9: A write to a channel's control word (field offset 3) is ignored while that channel's enable bit and the master bit are both set.
- R10: When a control word write is accepted, a 0 in bit 4 clears the end bit and a 1 in bit 4 leaves it unchanged.
- R11: A request still high after its acknowledge counts as a new request, so a held line is served again in the next arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | CAW | Register address: channel n field f at n*4+f, global word at 16 |
| cfg_wdata | input | RW | Register write data |
| cfg_rdata | output | RW | Registered read data for `cfg_addr` |
| dreq | input | NCH | Per-channel request level |
| dack | output | NCH | One-cycle acknowledge at the start of the read |
| nmi | input | 1 | Non-maskable interrupt pulse |
| mem_rd | output | 1 | Memory read strobe, data expected on `mem_rdata` in the same cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Byte written |
| mem_rdata | input | DW | Byte returned by memory |
| irq | output | NCH | Per-channel end-of-transfer interrupt |

## Verification
Assertions check the following on every cycle: the read-then-write ordering, the rule that the read and write strobes never overlap, the single-hot acknowledge and grant, and that channel 0 always wins when eligible. They also check that no transfer starts while the NMI flag is set or the master bit is clear, that a locked control word keeps its value, and that the end bit rises only with a zero counter. The bench scenarios show what depends on data and sequence. These are the final pointer values under each stepping mode, the bytes placed in memory, the full 0-3-2-1 service order when all four channels wait, and NMI recovery after a software clear. The bench also covers the rules for clearing the end bit and a held request being served repeatedly.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  // control word bit positions
  localparam int CB_EN   = 0;
  localparam int CB_SINC = 1;
  localparam int CB_DINC = 2;
  localparam int CB_IE   = 3;
  localparam int CB_TEND = 4;
  localparam int CTL_W   = 5;
  // global word bit positions
  localparam int GB_ME   = 0;
  localparam int GB_NMI  = 1;
  // per-channel field offsets
  localparam logic [1:0] FLD_SRC = 2'd0;
  localparam logic [1:0] FLD_DST = 2'd1;
  localparam logic [1:0] FLD_CNT = 2'd2;
  localparam logic [1:0] FLD_CTL = 2'd3;

  typedef enum logic [1:0] {SQ_IDLE, SQ_READ, SQ_WRITE} seq_state_t;
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        fld,
  input  logic [RW-1:0]     wdata,
  input  logic              me,
  input  logic              upd,
  output logic [AW-1:0]     src_o,
  output logic [AW-1:0]     dst_o,
  output logic [CW-1:0]     cnt_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              ready_o
);
  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic en, sinc, dinc, ie, tend;
  logic locked;

  assign locked = en && me;

  always_ff @(posedge clk) begin
    if (rst) begin
      src  <= '0;
      dst  <= '0;
      cnt  <= '0;
      en   <= 1'b0;
      sinc <= 1'b0;
      dinc <= 1'b0;
      ie   <= 1'b0;
      tend <= 1'b0;
    end else begin
      if (wr) begin
        case (fld)
          FLD_SRC: src <= wdata[AW-1:0];
          FLD_DST: dst <= wdata[AW-1:0];
          FLD_CNT: cnt <= wdata[CW-1:0];
          default: begin
            if (!locked) begin
              en   <= wdata[CB_EN];
              sinc <= wdata[CB_SINC];
              dinc <= wdata[CB_DINC];
              ie   <= wdata[CB_IE];
              if (!wdata[CB_TEND]) tend <= 1'b0;
            end
          end
        endcase
      end
      // a finished unit overrides a colliding register write
      if (upd) begin
        if (sinc) src <= src + 1'b1;
        if (dinc) dst <= dst + 1'b1;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) tend <= 1'b1;
      end
    end
  end

  assign src_o   = src;
  assign dst_o   = dst;
  assign cnt_o   = cnt;
  assign ctl_o   = {tend, ie, dinc, sinc, en};
  assign ready_o = en && !tend && (cnt != '0);

  // R9
  ctl_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && fld == FLD_CTL && locked) |=> ({en, sinc, dinc, ie} == $past({en, sinc, dinc, ie})));
  // R4
  tend_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tend) |-> (cnt == '0));
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int NCH = 4,
  parameter int IW  = 2,
  // slot k (k=0 highest) names the channel at bits [k*IW +: IW]
  parameter logic [NCH*IW-1:0] PRIO = {2'd1, 2'd2, 2'd3, 2'd0}
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] elig,
  output logic [NCH-1:0] gnt,
  output logic [IW-1:0]  gnt_idx,
  output logic           any
);
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (elig[PRIO[k*IW +: IW]]) begin
        gnt                    = '0;
        gnt[PRIO[k*IW +: IW]]  = 1'b1;
        gnt_idx                = PRIO[k*IW +: IW];
        any                    = 1'b1;
      end
    end
  end

  // R6
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  // R6
  gnt_valid_chk: assert property (@(posedge clk) disable iff (rst) (gnt & ~elig) == '0);
  // R6
  top_slot_chk: assert property (@(posedge clk) disable iff (rst)
    elig[PRIO[IW-1:0]] |-> gnt[PRIO[IW-1:0]]);
endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int IW  = 2,
  parameter int AW  = 16,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [IW-1:0]  start_idx,
  input  logic [AW-1:0]  start_src,
  input  logic [AW-1:0]  start_dst,
  input  logic [DW-1:0]  mem_rdata,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic [NCH-1:0] dack,
  output logic [NCH-1:0] upd,
  output logic           idle
);
  seq_state_t    st;
  logic [IW-1:0] cur;
  logic [AW-1:0] dst_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      cur       <= '0;
      dst_l     <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      dack      <= '0;
    end else begin
      dack <= '0;
      case (st)
        SQ_IDLE: begin
          if (start) begin
            st       <= SQ_READ;
            cur      <= start_idx;
            dst_l    <= start_dst;
            mem_rd   <= 1'b1;
            mem_addr <= start_src;
            dack     <= NCH'(1) << start_idx;
          end
        end
        SQ_READ: begin
          st        <= SQ_WRITE;
          mem_rd    <= 1'b0;
          mem_wr    <= 1'b1;
          mem_addr  <= dst_l;
          mem_wdata <= mem_rdata;
        end
        default: begin
          st     <= SQ_IDLE;
          mem_wr <= 1'b0;
        end
      endcase
    end
  end

  assign upd  = (st == SQ_WRITE) ? (NCH'(1) << cur) : '0;
  assign idle = (st == SQ_IDLE);

  // R2
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst) mem_rd |=> mem_wr);
  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));
  // R2
  dack_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(dack));
  // R2
  dack_with_rd_chk: assert property (@(posedge clk) disable iff (rst) (dack != '0) |-> mem_rd);
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int RW  = 16,
  parameter int DW  = 8,
  parameter int CAW = $clog2(NCH * 4) + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [RW-1:0]  cfg_wdata,
  output logic [RW-1:0]  cfg_rdata,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  input  logic           nmi,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic [NCH-1:0] irq
);
  localparam int IW = $clog2(NCH);

  logic          is_glob;
  logic [IW-1:0] ch_sel;
  logic [1:0]    fld;
  logic          me, nmi_f;

  logic [AW-1:0]    src_a [NCH];
  logic [AW-1:0]    dst_a [NCH];
  logic [CW-1:0]    cnt_a [NCH];
  logic [CTL_W-1:0] ctl_a [NCH];
  logic [NCH-1:0]   ready, elig, gnt, upd;
  logic [IW-1:0]    gnt_idx;
  logic             any, seq_idle;

  assign is_glob = cfg_addr[CAW-1];
  assign ch_sel  = cfg_addr[CAW-2:2];
  assign fld     = cfg_addr[1:0];

  // global word: master run bit and sticky NMI flag
  always_ff @(posedge clk) begin
    if (rst) begin
      me    <= 1'b0;
      nmi_f <= 1'b0;
    end else begin
      if (cfg_wr && is_glob) begin
        me <= cfg_wdata[GB_ME];
        if (!cfg_wdata[GB_NMI]) nmi_f <= 1'b0;
      end
      if (nmi) nmi_f <= 1'b1;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    dma4_chan #(.AW(AW), .CW(CW), .RW(RW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr      (cfg_wr && !is_glob && (ch_sel == IW'(n))),
      .fld     (fld),
      .wdata   (cfg_wdata),
      .me      (me),
      .upd     (upd[n]),
      .src_o   (src_a[n]),
      .dst_o   (dst_a[n]),
      .cnt_o   (cnt_a[n]),
      .ctl_o   (ctl_a[n]),
      .ready_o (ready[n])
    );
  end

  assign elig = ready & dreq & {NCH{me && !nmi_f}};

  dma4_arb #(.NCH(NCH), .IW(IW)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .elig    (elig),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any     (any)
  );

  dma4_seq #(.NCH(NCH), .IW(IW), .AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (any),
    .start_idx (gnt_idx),
    .start_src (src_a[gnt_idx]),
    .start_dst (dst_a[gnt_idx]),
    .mem_rdata (mem_rdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .dack      (dack),
    .upd       (upd),
    .idle      (seq_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
      irq       <= '0;
    end else begin
      for (int n = 0; n < NCH; n++) irq[n] <= ctl_a[n][CB_TEND] && ctl_a[n][CB_IE];
      if (is_glob) cfg_rdata <= RW'({nmi_f, me});
      else begin
        case (fld)
          FLD_SRC: cfg_rdata <= RW'(src_a[ch_sel]);
          FLD_DST: cfg_rdata <= RW'(dst_a[ch_sel]);
          FLD_CNT: cfg_rdata <= RW'(cnt_a[ch_sel]);
          default: cfg_rdata <= RW'(ctl_a[ch_sel]);
        endcase
      end
    end
  end

  // R8
  nmi_latch_chk: assert property (@(posedge clk) disable iff (rst) nmi |=> nmi_f);
  // R8
  nmi_block_chk: assert property (@(posedge clk) disable iff (rst) $rose(mem_rd) |-> !$past(nmi_f));
  // R7
  me_gate_chk: assert property (@(posedge clk) disable iff (rst) $rose(mem_rd) |-> $past(me));
  // R2
  start_idle_chk: assert property (@(posedge clk) disable iff (rst) (any && seq_idle) |=> mem_rd);
endmodule

// File: tb/sim_dma4_ctrl.sv
`timescale 1ns/1ps
module sim_dma4_ctrl;
  localparam int GLOB = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr;
  logic [4:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic [3:0]  dreq, dack, irq;
  logic        nmi, mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  mem [256];
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  dma4_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dreq(dreq), .dack(dack), .nmi(nmi), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .irq(irq)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = 5'(a);
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic count_acks(input int cyc, output int n);
    n = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (dack != 0) n++;
    end
  endtask

  function automatic int ra(input int ch, input int f);
    return ch * 4 + f;
  endfunction

  // expected source byte for unit k of a channel
  function automatic logic [7:0] src_byte(input int s0, input bit sinc, input int k);
    return mem[(s0 + (sinc ? k : 0)) & 255];
  endfunction

  initial begin : wdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    int n;
    int order [4];
    int oc;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    mem[16'h10] = 8'h5A;
    rst = 1'b1; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0; dreq = '0; nmi = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 strobes", {mem_rd, mem_wr, dack, irq}, 0);
    rd(ra(3, 2), v); chk("R1 count", v, 0);
    rd(ra(0, 3), v); chk("R1 ctl", v, 0);
    rd(GLOB, v);     chk("R1 global", v, 0);

    // single channel, fixed source, stepping destination
    wr(ra(1, 0), 16'h0010); wr(ra(1, 1), 16'h0080); wr(ra(1, 2), 2);
    wr(ra(1, 3), 16'h000D); wr(GLOB, 1);
    @(negedge clk); dreq[1] = 1'b1;
    @(negedge clk);
    chk("R2 dack", dack, 4'b0010);
    chk("R2 read", {mem_rd, mem_wr, mem_addr}, {2'b10, 16'h0010});
    dreq[1] = 1'b0;
    @(negedge clk);
    chk("R2 write", {mem_rd, mem_wr, mem_addr, mem_wdata}, {2'b01, 16'h0080, 8'h5A});
    chk("R2 dack one cycle", dack, 0);
    @(negedge clk);
    chk("R2 memory", mem[16'h80], 8'h5A);
    rd(ra(1, 2), v); chk("R4 count step", v, 1);
    rd(ra(1, 1), v); chk("R3 dst step", v, 16'h0081);
    rd(ra(1, 0), v); chk("R3 src fixed", v, 16'h0010);
    dreq[1] = 1'b1; @(negedge clk); dreq[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(ra(1, 2), v); chk("R4 count zero", v, 0);
    rd(ra(1, 3), v); chk("R4 end bit", v, 16'h001D);
    chk("R5 irq", irq, 4'b0010);
    dreq[1] = 1'b1; count_acks(8, n); dreq[1] = 1'b0;
    chk("R4 stopped", n, 0);

    // R9 locked control word
    wr(ra(1, 3), 16'h0000);
    rd(ra(1, 3), v); chk("R9 write ignored", v, 16'h001D);
    // R10 end bit clearing
    wr(GLOB, 0);
    wr(ra(1, 3), 16'h001C);
    rd(ra(1, 3), v); chk("R10 one keeps end", v, 16'h001C);
    wr(ra(1, 3), 16'h000C);
    rd(ra(1, 3), v); chk("R10 zero clears end", v, 16'h000C);
    chk("R5 irq cleared", irq, 0);

    // R7 enable gating
    wr(ra(1, 2), 1); wr(ra(1, 3), 16'h000D);
    dreq[1] = 1'b1; count_acks(6, n); chk("R7 master off", n, 0);
    wr(ra(1, 3), 16'h000C); wr(GLOB, 1);
    count_acks(6, n); chk("R7 channel off", n, 0);
    wr(GLOB, 0); wr(ra(1, 3), 16'h000D); wr(GLOB, 1);
    count_acks(6, n); chk("R7 both on", n, 1);
    dreq[1] = 1'b0;

    // R8 NMI flag
    @(negedge clk); nmi = 1'b1; @(negedge clk); nmi = 1'b0;
    rd(GLOB, v); chk("R8 latched", v, 3);
    wr(ra(2, 0), 16'h0020); wr(ra(2, 1), 16'h0090); wr(ra(2, 2), 2); wr(ra(2, 3), 16'h000F);
    dreq[2] = 1'b1; count_acks(8, n); chk("R8 blocks", n, 0);
    wr(GLOB, 3);
    rd(GLOB, v); chk("R8 write one keeps", v, 3);
    // R11 held request served once per unit
    wr(GLOB, 1);
    count_acks(12, n); chk("R11 held request", n, 2);
    dreq[2] = 1'b0;
    rd(ra(2, 2), v); chk("R8 resumed", v, 0);
    rd(GLOB, v); chk("R8 cleared", v, 1);

    // R6 priority with all four waiting
    wr(GLOB, 0);
    for (int c = 0; c < 4; c++) begin
      wr(ra(c, 0), 16'(c * 8)); wr(ra(c, 1), 16'(16'hC0 + c)); wr(ra(c, 2), 1);
      wr(ra(c, 3), 16'h000D);
    end
    dreq = 4'hF;
    wr(GLOB, 1);
    oc = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dack != 0 && oc < 4) begin
        for (int c = 0; c < 4; c++) if (dack[c]) order[oc] = c;
        oc++;
      end
    end
    dreq = '0;
    chk("R6 count", oc, 4);
    chk("R6 first", order[0], 0);
    chk("R6 second", order[1], 3);
    chk("R6 third", order[2], 2);
    chk("R6 fourth", order[3], 1);

    // random rounds
    for (int r = 0; r < 3; r++) begin
      int s0 [4]; int d0 [4]; int cn [4]; bit si [4]; bit di [4];
      wr(GLOB, 0);
      for (int i = 128; i < 256; i++) mem[i] = 8'h00;
      for (int c = 0; c < 4; c++) begin
        si[c] = 1'($urandom); di[c] = 1'($urandom);
        cn[c] = 1 + int'($urandom % 5);
        s0[c] = c * 32 + int'($urandom % 16);
        d0[c] = 128 + c * 32;
        wr(ra(c, 0), 16'(s0[c])); wr(ra(c, 1), 16'(d0[c])); wr(ra(c, 2), 16'(cn[c]));
        wr(ra(c, 3), 16'(1 | (int'(si[c]) << 1) | (int'(di[c]) << 2) | 8));
      end
      wr(GLOB, 1);
      for (int i = 0; i < 400 && irq != 4'hF; i++) begin
        @(negedge clk); dreq = 4'($urandom);
      end
      @(negedge clk); dreq = '0;
      repeat (4) @(negedge clk);
      chk("R5 all done", irq, 4'hF);
      for (int c = 0; c < 4; c++) begin
        rd(ra(c, 2), v); chk("R4 random count", v, 0);
        rd(ra(c, 0), v); chk("R3 random src", v, 16'(s0[c] + (si[c] ? cn[c] : 0)));
        rd(ra(c, 1), v); chk("R3 random dst", v, 16'(d0[c] + (di[c] ? cn[c] : 0)));
        if (di[c]) begin
          for (int k = 0; k < cn[c]; k++)
            chk("R2 random data", mem[d0[c] + k], src_byte(s0[c], si[c], k));
        end else begin
          chk("R2 random data fixed", mem[d0[c]], src_byte(s0[c], si[c], cn[c] - 1));
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule